// File: doc/BRIEF.md
# Isolated Gate Output Decoder

This block sits on the receive side of a two-channel isolation link and produces the logic levels for two gate drivers. Each channel receives narrow set and clear pulses. A set pulse marks a rising input and a clear pulse marks a falling input. The transmit side also repeats the pulse for the current level as a refresh while the input is idle. Each channel keeps its level in a bistable register, so the output stays correct between pulses.

Each channel has its own missing-pulse watchdog. If the pulse stream stops for longer than the timeout, the link is treated as dead. The stored level is then cleared and the output falls to its default low level.

A supply-good input stands in for under-voltage lockout on the output side. While it is low, both outputs are held low. A cross-channel interlock prevents shoot-through: whenever both decoded levels are high, both outputs go low.

Top module: `iso_gate_decoder`

## Requirements
- R1: On a channel, a set pulse (set high, clear low) makes the stored level high and a clear pulse (clear high, set low) makes it low. The level holds while no pulse arrives. The gate output follows the stored level on the second rising clock edge after the pulse is sampled.
- R2: A cycle with both set and clear high on a channel leaves that channel's stored level unchanged. It still counts as a pulse for the watchdog.
- R3: When a channel has seen no pulse for LIMIT = CYCLES_PER_US*TIMEOUT_US consecutive clock edges, its gate output is low from the following edge on.
- R4: A watchdog timeout clears the stored level. After a timeout, a pulse with both set and clear high leaves the output low, and only a set pulse makes it high again.
- R5: While supply_ok is low, both gate outputs are low on the next edge. Once supply_ok returns high, the outputs follow the decoded levels on the next edge, which is well within 1 µs.
- R6: The interlock gives gate_a = A & ~B and gate_b = B & ~A, where A and B are the live decoded levels. The outputs are never both high.
- R7: After reset, both stored levels are low, both watchdogs are expired and both outputs are low. The outputs stay low until pulses arrive.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| set_a | input | 1 | Set pulse, channel A |
| clr_a | input | 1 | Clear pulse, channel A |
| set_b | input | 1 | Set pulse, channel B |
| clr_b | input | 1 | Clear pulse, channel B |
| supply_ok | input | 1 | Output supply good; low holds both outputs low |
| gate_a | output | 1 | Gate drive level, channel A |
| gate_b | output | 1 | Gate drive level, channel B |

## Verification
The hardest situation to reach from the ports is a timeout that strikes while a channel holds a high level, followed by a pulse that reloads the watchdog but must not bring the level back. The stimulus reaches it directly. It sets channel A, stays silent for exactly LIMIT edges and then for one edge more. It then sends a pulse with set and clear both high and checks that the output stays low. Random phases add long silent gaps on one channel at a time, so that timeouts mix with interlock and lockout conditions on the other channel.

// File: rtl/iso_gate_decoder.sv
module iso_gate_decoder #(
  parameter int CYCLES_PER_US = 200,
  parameter int TIMEOUT_US    = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set_a,
  input  logic clr_a,
  input  logic set_b,
  input  logic clr_b,
  input  logic supply_ok,
  output logic gate_a,
  output logic gate_b
);
  localparam int LIMIT = CYCLES_PER_US * TIMEOUT_US;
  localparam int CW    = $clog2(LIMIT + 1);

  logic [1:0] hit_set, hit_clr, lvl, alive, dec;

  assign hit_set = {set_b, set_a};
  assign hit_clr = {clr_b, clr_a};
  assign dec     = lvl & alive;

  for (genvar ch = 0; ch < 2; ch++) begin : g_ch
    logic [CW-1:0] cnt;
    logic          pulse;

    assign pulse     = hit_set[ch] | hit_clr[ch];
    assign alive[ch] = (cnt != '0);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt     <= '0;
        lvl[ch] <= 1'b0;
      end else if (pulse) begin
        cnt <= CW'(LIMIT);
        if (hit_set[ch] && !hit_clr[ch])      lvl[ch] <= 1'b1;
        else if (hit_clr[ch] && !hit_set[ch]) lvl[ch] <= 1'b0;
      end else if (cnt <= CW'(1)) begin
        cnt     <= '0;
        lvl[ch] <= 1'b0;
      end else begin
        cnt <= cnt - CW'(1);
      end
    end

    // R2
    hold_on_conflict_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_set[ch] && hit_clr[ch]) |=> $stable(lvl[ch]));
    // R1
    set_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_set[ch] && !hit_clr[ch]) |=> lvl[ch]);
    // R3
    expired_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!alive[ch]) |-> !lvl[ch]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_a <= 1'b0;
      gate_b <= 1'b0;
    end else begin
      gate_a <= supply_ok & dec[0] & ~dec[1];
      gate_b <= supply_ok & dec[1] & ~dec[0];
    end
  end

  // R6
  no_shoot_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate_a && gate_b));
  // R5
  lockout_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |=> (!gate_a && !gate_b));
  // R3
  dead_link_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !alive[0] |=> !gate_a);
endmodule

// File: tb/iso_gate_decoder_tb.sv
module iso_gate_decoder_tb;
  localparam int CPU   = 200;
  localparam int TUS   = 5;
  localparam int LIMIT = CPU * TUS;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic set_a = 0, clr_a = 0, set_b = 0, clr_b = 0, supply_ok = 0;
  logic gate_a, gate_b;

  int checks = 0, failures = 0;
  bit done = 0;

  bit m_lvl[2];
  int m_cnt[2];
  bit e_a = 0, e_b = 0;

  always #2.5 clk = ~clk;

  iso_gate_decoder #(.CYCLES_PER_US(CPU), .TIMEOUT_US(TUS)) u_dut (
    .clk(clk), .rst_n(rst_n), .set_a(set_a), .clr_a(clr_a),
    .set_b(set_b), .clr_b(clr_b), .supply_ok(supply_ok),
    .gate_a(gate_a), .gate_b(gate_b));

  function automatic bit live(input bit l, input int c);
    return l && (c != 0);
  endfunction

  task automatic chk(input string tag, input bit act, input bit exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_ch(input int ch, input bit s, input bit c);
    if (s || c) begin
      m_cnt[ch] = LIMIT;
      if (s && !c) m_lvl[ch] = 1;
      else if (c && !s) m_lvl[ch] = 0;
    end else if (m_cnt[ch] <= 1) begin
      m_cnt[ch] = 0;
      m_lvl[ch] = 0;
    end else m_cnt[ch]--;
  endtask

  task automatic step(input string tag, input bit sa, input bit ca,
                      input bit sb, input bit cb, input bit ok, input bit do_chk = 1);
    bit la, lb;
    @(negedge clk);
    set_a = sa; clr_a = ca; set_b = sb; clr_b = cb; supply_ok = ok;
    @(posedge clk);
    la = live(m_lvl[0], m_cnt[0]);
    lb = live(m_lvl[1], m_cnt[1]);
    e_a = ok & la & ~lb;
    e_b = ok & lb & ~la;
    model_ch(0, sa, ca);
    model_ch(1, sb, cb);
    #1;
    if (do_chk) begin
      chk({tag, " gate_a"}, gate_a, e_a);
      chk({tag, " gate_b"}, gate_b, e_b);
    end
  endtask

  task automatic idle(input string tag, input int n, input bit ok = 1);
    for (int i = 0; i < n; i++) step(tag, 0, 0, 0, 0, ok, (i % 50 == 0));
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog timeout");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    bit r;
    m_lvl[0] = 0; m_lvl[1] = 0; m_cnt[0] = 0; m_cnt[1] = 0;
    repeat (3) @(posedge clk);
    #1;
    chk("R7 reset gate_a", gate_a, 0);
    chk("R7 reset gate_b", gate_b, 0);
    @(negedge clk); rst_n = 1;
    supply_ok = 1;
    // R7: no pulses yet, outputs stay low
    for (int i = 0; i < 5; i++) step("R7", 0, 0, 0, 0, 1);

    // R1: set A, observe on second edge
    step("R1", 1, 0, 0, 0, 1);
    step("R1", 0, 0, 0, 0, 1);
    chk("R1 set A seen", gate_a, 1);
    idle("R1 hold", 20);
    step("R1", 0, 1, 0, 0, 1);
    step("R1", 0, 0, 0, 0, 1);
    chk("R1 clear A seen", gate_a, 0);

    // R6 interlock truth table
    step("R6", 0, 0, 1, 0, 1); step("R6", 0, 0, 0, 0, 1);
    chk("R6 only B", gate_b, 1);
    step("R6", 1, 0, 0, 0, 1); step("R6", 0, 0, 0, 0, 1);
    chk("R6 both high a", gate_a, 0);
    chk("R6 both high b", gate_b, 0);
    step("R6", 0, 0, 0, 1, 1); step("R6", 0, 0, 0, 0, 1);
    chk("R6 only A", gate_a, 1);

    // R2: conflict holds level
    step("R2", 1, 1, 0, 0, 1); step("R2", 0, 0, 0, 0, 1);
    chk("R2 conflict holds high", gate_a, 1);
    step("R2", 0, 1, 0, 0, 1); step("R2", 1, 1, 0, 0, 1); step("R2", 0, 0, 0, 0, 1);
    chk("R2 conflict holds low", gate_a, 0);

    // R5 lockout
    step("R5", 1, 0, 0, 0, 1); step("R5", 0, 0, 0, 0, 0);
    chk("R5 lockout a", gate_a, 0);
    step("R5", 0, 0, 0, 0, 1);
    chk("R5 resume a", gate_a, 1);

    // R3 timeout boundary: refresh A, then LIMIT silent edges
    step("R3", 1, 0, 0, 1, 1);
    for (int i = 0; i < LIMIT; i++) step("R3", 0, 0, 0, 0, 1, (i > LIMIT - 4));
    chk("R3 last live edge", gate_a, 1);
    step("R3", 0, 0, 0, 0, 1);
    chk("R3 expired", gate_a, 0);

    // R4 conflict pulse after timeout cannot restore high
    step("R4", 1, 1, 0, 0, 1); step("R4", 0, 0, 0, 0, 1);
    chk("R4 stays low after timeout", gate_a, 0);
    step("R4", 1, 0, 0, 0, 1); step("R4", 0, 0, 0, 0, 1);
    chk("R4 set restores", gate_a, 1);

    // random phase, fixed seed
    r = $urandom(32'h5eed);
    for (int seg = 0; seg < 40; seg++) begin
      int n = (seg % 5 == 4) ? LIMIT + 10 : 60;
      bit quiet_a = (seg % 10 == 4);
      for (int i = 0; i < n; i++) begin
        bit sa = 0, ca = 0, sb = 0, cb = 0, ok;
        if (!quiet_a && ($urandom % 8 == 0)) begin sa = $urandom; ca = $urandom; end
        if (($urandom % 8 == 0) && (seg % 10 != 9)) begin sb = $urandom; cb = $urandom; end
        ok = ($urandom % 16 != 0);
        step(!ok ? "R5 rand" : "R6 rand", sa, ca, sb, cb, ok, (n < 100) || (i % 20 == 0) || (i > n - 12));
      end
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule